// File: doc/BRIEF.md
# Quadrature Encoder Position Decoder

This block turns the two phase outputs of an incremental rotary encoder, plus its once-per-turn index mark, into an absolute shaft position. Every transition on either phase counts as one step, so an encoder with N lines gives 4·N counts per turn. The count runs from zero up to a programmable, zero-based limit and wraps in both directions. The block also keeps a direction flag, and it flags a sample in which both phases moved at once as a phase error.

Four event sources feed a latched interrupt: phase error, direction change, index seen, and a pulse from an external velocity timer. Each source has a mask bit, a raw view, a masked view and a write-one-to-clear path. Software reaches everything through a small word-addressed register port. Reads are combinational from the registered state. Writes take effect at the clock edge on which `reg_we` is high. The register port has no flow control: each access completes in a single cycle, so it can never apply back-pressure. Phase and index inputs are asynchronous and are synchronized inside the block.

Register map (address: contents): 0 control (bit 0 run, bit 1 zero-on-index), 1 position limit, 2 position (read only), 3 status (bit 0 direction, 1 = forward), 4 interrupt mask, 5 raw events (read only), 6 masked events (read only), 7 event clear (write only, reads 0). The event bit order is: bit 0 phase error, bit 1 direction change, bit 2 index, bit 3 velocity timer.

Top module: `qdec_top`

## Requirements
- R1: After reset every register address (0 to 7) reads zero, `dir_fwd` is low and `irq` is low.
- R2: With the run bit (control bit 0) set, the phase code {A,B} stepping 00→10→11→01→00 adds one to the position per transition, and the reverse order subtracts one. A phase change applied to the pins is visible at address 2 by the third rising clock edge after it.
- R3: A forward step taken while the position equals the limit (address 1) makes the position 0.
- R4: A backward step taken while the position is 0 makes the position equal to the limit.
- R5: While the run bit is clear, phase and index activity leave the position, the direction flag and event bits 0 to 2 unchanged.
- R6: A rising edge on `enc_idx` while running sets event bit 2. It sets the position to 0 only when control bit 1 is set; otherwise the position is left as it is.
- R7: A sample in which both phases changed sets event bit 0 and leaves the position unchanged.
- R8: Status bit 0 and `dir_fwd` show the sign of the last valid step (1 = forward). A valid step whose sign differs from the flag sets event bit 1. Because the flag resets to 0, the first forward step after reset counts as a change.
- R9: A one-cycle pulse on `vel_tick` sets event bit 3, whether or not the run bit is set.
- R10: Writing 1s to address 7 clears the matching raw event bits. Address 6 reads raw AND mask (mask at address 4). `irq` is high exactly when that masked value is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index mark, asynchronous |
| vel_tick | input | 1 | One-cycle expiry pulse from the velocity timer |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| dir_fwd | output | 1 | Direction flag, 1 = forward |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with an 8-bit position and programs a limit of 5, so a run of a few dozen steps crosses both wrap points several times in each direction. This makes it practical to compare every single step against an arithmetic modulo-(limit+1) model. With only four phase states, illegal double transitions from several phase states, index behaviour with and without zero-on-index, and every event bit's set, mask and clear paths are all exercised within a short run.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int REG_AW = 3;
  localparam int EV_N   = 4;

  localparam int EV_PERR  = 0;
  localparam int EV_DIRC  = 1;
  localparam int EV_INDEX = 2;
  localparam int EV_VEL   = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 3'd0,
    RA_LIMIT = 3'd1,
    RA_POS   = 3'd2,
    RA_STAT  = 3'd3,
    RA_MASK  = 3'd4,
    RA_RAW   = 3'd5,
    RA_MSTAT = 3'd6,
    RA_CLR   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic step;  // exactly one phase moved
    logic fwd;   // sign of that move
    logic err;   // both phases moved
  } step_t;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a,
  input  logic  b,
  input  logic  idx,
  output step_t st,
  output logic  idx_rise
);
  logic pa, pb, pidx;
  logic ch_a, ch_b;

  // previous samples follow the pins even when the counter is halted,
  // so enabling never sees a stale transition
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa   <= 1'b0;
      pb   <= 1'b0;
      pidx <= 1'b0;
    end else begin
      pa   <= a;
      pb   <= b;
      pidx <= idx;
    end
  end

  assign ch_a     = a ^ pa;
  assign ch_b     = b ^ pb;
  assign st.step  = ch_a ^ ch_b;
  assign st.err   = ch_a & ch_b;
  assign st.fwd   = pb ^ a;
  assign idx_rise = idx & ~pidx;
endmodule

// File: rtl/qdec_pos.sv
module qdec_pos
  import qdec_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             zero_on_idx,
  input  logic [POS_W-1:0] limit,
  input  step_t            st,
  input  logic             idx_rise,
  output logic [POS_W-1:0] pos,
  output logic             dir,
  output logic             ev_perr,
  output logic             ev_dirc,
  output logic             ev_index
);
  logic [POS_W-1:0] pos_inc, pos_dec, pos_nxt;
  logic             valid_step;

  assign valid_step = run & st.step;
  assign pos_inc    = (pos >= limit) ? '0 : pos + 1'b1;
  assign pos_dec    = (pos == '0) ? limit : pos - 1'b1;

  always_comb begin
    pos_nxt = pos;
    if (run & idx_rise & zero_on_idx) pos_nxt = '0;
    else if (valid_step)              pos_nxt = st.fwd ? pos_inc : pos_dec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      dir <= 1'b0;
    end else begin
      pos <= pos_nxt;
      if (valid_step) dir <= st.fwd;
    end
  end

  assign ev_perr  = run & st.err;
  assign ev_dirc  = valid_step & (st.fwd != dir);
  assign ev_index = run & idx_rise;
endmodule

// File: rtl/qdec_irq.sv
module qdec_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_src
    // a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n)                 raw[i] <= 1'b0;
      else if (ev[i])             raw[i] <= 1'b1;
      else if (clr_we && wdata[i]) raw[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= wdata;
  end

  assign irq = |(raw & mask);
endmodule

// File: rtl/qdec_top.sv
module qdec_top
  import qdec_pkg::*;
#(
  parameter int POS_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_idx,
  input  logic              vel_tick,
  input  logic [2:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dir_fwd,
  output logic              irq
);
  localparam int CTRL_W = 2;

  logic [2:0]        pins_s;
  step_t             st;
  logic              idx_rise;
  logic [CTRL_W-1:0] ctrl_q;
  logic [POS_W-1:0]  limit_q, pos_q;
  logic              dir_q;
  logic              ev_perr, ev_dirc, ev_index;
  logic [EV_N-1:0]   ev_vec, raw_q, mask_q;
  logic              wr_ctrl, wr_limit, wr_mask, wr_clr;

  qdec_sync #(.N(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({enc_idx, enc_b, enc_a}),
    .q     (pins_s)
  );

  qdec_step u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .a        (pins_s[0]),
    .b        (pins_s[1]),
    .idx      (pins_s[2]),
    .st       (st),
    .idx_rise (idx_rise)
  );

  qdec_pos #(.POS_W(POS_W)) u_pos (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (ctrl_q[0]),
    .zero_on_idx (ctrl_q[1]),
    .limit       (limit_q),
    .st          (st),
    .idx_rise    (idx_rise),
    .pos         (pos_q),
    .dir         (dir_q),
    .ev_perr     (ev_perr),
    .ev_dirc     (ev_dirc),
    .ev_index    (ev_index)
  );

  always_comb begin
    ev_vec           = '0;
    ev_vec[EV_PERR]  = ev_perr;
    ev_vec[EV_DIRC]  = ev_dirc;
    ev_vec[EV_INDEX] = ev_index;
    ev_vec[EV_VEL]   = vel_tick;
  end

  assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
  assign wr_limit = reg_we && (reg_addr == RA_LIMIT);
  assign wr_mask  = reg_we && (reg_addr == RA_MASK);
  assign wr_clr   = reg_we && (reg_addr == RA_CLR);

  qdec_irq #(.N(EV_N)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev_vec),
    .clr_we  (wr_clr),
    .mask_we (wr_mask),
    .wdata   (reg_wdata[EV_N-1:0]),
    .raw     (raw_q),
    .mask    (mask_q),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      limit_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= reg_wdata[CTRL_W-1:0];
      if (wr_limit) limit_q <= reg_wdata[POS_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl_q;
      RA_LIMIT: reg_rdata[POS_W-1:0]  = limit_q;
      RA_POS:   reg_rdata[POS_W-1:0]  = pos_q;
      RA_STAT:  reg_rdata[0]          = dir_q;
      RA_MASK:  reg_rdata[EV_N-1:0]   = mask_q;
      RA_RAW:   reg_rdata[EV_N-1:0]   = raw_q;
      RA_MSTAT: reg_rdata[EV_N-1:0]   = raw_q & mask_q;
      default:  reg_rdata             = '0;
    endcase
  end

  assign dir_fwd = dir_q;
endmodule

// File: rtl/qdec_chk.sv
module qdec_chk
  import qdec_pkg::*;
#(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             zero_on_idx,
  input step_t            st,
  input logic             idx_rise,
  input logic [POS_W-1:0] pos,
  input logic [POS_W-1:0] limit,
  input logic [EV_N-1:0]  raw,
  input logic [EV_N-1:0]  mask,
  input logic             irq
);
  assert_hold_when_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pos));

  assert_fwd_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st.step && st.fwd && pos == limit && !idx_rise) |=> (pos == '0));

  assert_bwd_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st.step && !st.fwd && pos == '0 && !idx_rise) |=> (pos == $past(limit)));

  assert_err_keeps_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st.err && !idx_rise) |=> $stable(pos));

  assert_err_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st.err) |=> raw[EV_PERR]);

  assert_index_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && idx_rise && zero_on_idx) |=> (pos == '0));

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

bind qdec_top qdec_chk #(.POS_W(POS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (ctrl_q[0]),
  .zero_on_idx (ctrl_q[1]),
  .st          (st),
  .idx_rise    (idx_rise),
  .pos         (pos_q),
  .limit       (limit_q),
  .raw         (raw_q),
  .mask        (mask_q),
  .irq         (irq)
);

// File: tb/sim_qdec_top.sv
module sim_qdec_top;
  localparam int PW  = 8;
  localparam int LIM = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, vel_tick = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dir_fwd, irq;

  int checks = 0;
  int failures = 0;

  // model state
  int ph = 0;
  int mpos = 0;
  int mdir = 0;
  logic [3:0] mraw = '0;

  always #10 clk = ~clk;

  qdec_top #(.POS_W(PW), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .vel_tick(vel_tick), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dir_fwd(dir_fwd), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wr(input logic [2:0] a, input int v);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = v;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic apply_ph(input int p);
    @(negedge clk);
    case (p & 3)
      0: begin enc_a = 1'b0; enc_b = 1'b0; end
      1: begin enc_a = 1'b1; enc_b = 1'b0; end
      2: begin enc_a = 1'b1; enc_b = 1'b1; end
      default: begin enc_a = 1'b0; enc_b = 1'b1; end
    endcase
    repeat (4) @(negedge clk);
  endtask

  task automatic mv(input int fwd, input int running);
    ph = fwd ? (ph + 1) & 3 : (ph + 3) & 3;
    apply_ph(ph);
    if (running) begin
      mpos = fwd ? (mpos + 1) % (LIM + 1) : (mpos + LIM) % (LIM + 1);
      if (fwd != mdir) mraw[1] = 1'b1;
      mdir = fwd;
    end
  endtask

  task automatic idx_pulse();
    @(negedge clk); enc_idx = 1'b1;
    repeat (4) @(negedge clk);
    enc_idx = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 dir", int'(dir_fwd), 0);
    chk("R1 irq", int'(irq), 0);

    // R5: halted counter ignores phases and index
    wr(3'd1, LIM);
    mv(1, 0); mv(1, 0); idx_pulse();
    rd(3'd2, v); chk("R5 pos", v, 0);
    rd(3'd5, v); chk("R5 raw", v, 0);
    chk("R5 dir", int'(dir_fwd), 0);

    // R2/R3: forward sweep across several wraps
    wr(3'd0, 1);
    for (int i = 0; i < 3 * (LIM + 1) + 2; i++) begin
      mv(1, 1);
      rd(3'd2, v); chk("R2/R3 fwd pos", v, mpos);
    end
    rd(3'd3, v); chk("R8 stat fwd", v, 1);
    chk("R8 pin fwd", int'(dir_fwd), 1);
    rd(3'd5, v); chk("R8 raw dirchg", v, int'(mraw));

    // R10: clear
    wr(3'd7, 15); mraw = '0;
    rd(3'd5, v); chk("R10 cleared", v, 0);

    // R2/R4: backward sweep
    for (int i = 0; i < 3 * (LIM + 1) + 2; i++) begin
      mv(0, 1);
      rd(3'd2, v); chk("R2/R4 bwd pos", v, mpos);
    end
    chk("R8 pin bwd", int'(dir_fwd), 0);
    rd(3'd5, v); chk("R8 raw bwd", v, int'(mraw));
    wr(3'd7, 15); mraw = '0;

    // R7: double transitions from each phase state
    for (int k = 0; k < 4; k++) begin
      mv(1, 1);
      wr(3'd7, 15); mraw = '0;
      ph = (ph + 2) & 3;
      apply_ph(ph);
      rd(3'd2, v); chk("R7 pos kept", v, mpos);
      rd(3'd5, v); chk("R7 raw err", v, 1);
      wr(3'd7, 1);
    end

    // R6: index without zeroing
    mv(1, 1); mv(1, 1);
    wr(3'd7, 15); mraw = '0;
    idx_pulse();
    rd(3'd2, v); chk("R6 pos kept", v, mpos);
    rd(3'd5, v); chk("R6 raw idx", v, 4);
    // R6: index with zeroing
    wr(3'd0, 3);
    if (mpos == 0) mv(1, 1);
    idx_pulse(); mpos = 0;
    rd(3'd2, v); chk("R6 pos zeroed", v, 0);
    wr(3'd7, 15); mraw = '0;

    // R9: velocity tick, also while halted
    wr(3'd0, 0);
    @(negedge clk); vel_tick = 1'b1;
    @(negedge clk); vel_tick = 1'b0;
    rd(3'd5, v); chk("R9 raw vel", v, 8);

    // R10: masking and irq
    chk("R10 irq unmasked", int'(irq), 0);
    wr(3'd4, 4);
    rd(3'd6, v); chk("R10 mstat none", v, 0);
    chk("R10 irq other", int'(irq), 0);
    wr(3'd4, 8);
    rd(3'd6, v); chk("R10 mstat vel", v, 8);
    chk("R10 irq on", int'(irq), 1);
    wr(3'd7, 8);
    rd(3'd5, v); chk("R10 raw after clr", v, 0);
    chk("R10 irq off", int'(irq), 0);
    rd(3'd7, v); chk("R10 clr reads 0", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule